// File: doc/BRIEF.md
# FSK Half-Bit Symbol Recovery

This block sits behind the sample path of a low-frequency reader that listens to a two-tone FSK answer. Every accepted 8-bit envelope sample is cut to one bit against a fixed threshold. The block counts the samples between successive rising edges of that bit and sorts each spacing into one of two tones: the short carrier period (fc/8) or the long one (fc/10). The sorting has a tolerance band, so noisy spacings from 7 to 11 still land in the right tone.

Runs of equal tone are then collected. When the tone changes, the length of the finished run is rounded to a whole number of half-bit periods. The divisor is six cycles for the short tone and five for the long tone. The filler cycles a transmitter inserts between nibbles disappear in this rounding. A finished run worth one to four half-bits produces that many copies of its symbol on the output stream. Any other value produces nothing. A run worth three half-bits marks a frame start. A run worth four appears when a logical 0 is directly followed by the next frame start. Frame decoding is done further downstream.

Both data edges are valid/ready streams. An output beat holds its symbol until the consumer accepts it. The input drops `smp_ready` for as long as any symbol of a finished run is still waiting, so back-pressure from the output propagates back to the sample source. A sample is consumed only on a cycle where `smp_valid` and `smp_ready` are both high.

Top module: `fsk_halfbit_recover`

## Requirements
- R1: An accepted sample with a value below 127 is taken as bit 0. A value of 127 or more is taken as bit 1.
- R2: No spacing is measured and no symbol is produced until a 0-to-1 transition of the sample bit has been seen after reset. The first sample after reset can never count as a transition.
- R3: The spacing between two consecutive 0-to-1 transitions, counted in accepted samples, is classified as the short tone when it is below 9 and as the long tone otherwise.
- R4: Consecutive equal classifications form one run. A run is closed only when a classification of the other tone arrives, and that classification starts the next run with length 1.
- R5: A closed short-tone run of length n is worth (n+1)/6 half-bits, and a closed long-tone run is worth (n+1)/5 half-bits, both with integer division.
- R6: A closed run worth 1, 2, 3 or 4 half-bits emits exactly that many output symbols. A run worth 0 or more than 4 emits none.
- R7: The emitted symbol `sym_bit` is 1 for a long-tone run and 0 for a short-tone run. Symbols leave in the order their runs closed.
- R8: The spacing counter saturates at 15. A gap of any length between transitions classifies as the long tone and never wraps into a short spacing.
- R9: While `sym_valid` is high and `sym_ready` is low, `sym_valid` stays high and `sym_bit` is unchanged. `smp_ready` is low whenever a symbol is pending.
- R10: After reset `sym_valid` is 0 and `smp_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample stream valid |
| smp_ready | output | 1 | Sample stream ready; low while symbols are pending |
| smp_data | input | 8 | Envelope sample value |
| sym_valid | output | 1 | Symbol stream valid |
| sym_ready | input | 1 | Symbol stream ready |
| sym_bit | output | 1 | Half-bit symbol: 1 long tone, 0 short tone |

## Verification
The assertions assume the consumer may hold `sym_ready` low for any number of cycles. They also assume that samples only count when the handshake completes, so a spacing is measured in accepted samples rather than clock cycles. The stimulus is built from whole carrier cycles, each one high sample followed by lows, so every spacing the design sees is the period the bench chose. This holds whether `sym_ready` is held high or toggled pseudo-randomly. Directed sequences place run lengths on both sides of each rounding step, include a 24-sample gap that a wrapping counter would misread, and use levels 126 and 127 to sit on the threshold.

// File: rtl/fsk_pkg.sv
package fsk_pkg;
  // Tone of one measured carrier cycle; value doubles as the emitted symbol.
  typedef enum logic {
    TONE_SHORT = 1'b0,
    TONE_LONG  = 1'b1
  } tone_e;
endpackage

// File: rtl/fsk_edge_timer.sv
module fsk_edge_timer
  import fsk_pkg::*;
#(
  parameter int SMP_W  = 8,
  parameter int THRESH = 127,
  parameter int CNT_W  = 4,
  parameter int SPLIT  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_i,
  input  logic [SMP_W-1:0] smp_i,
  output logic             cls_fire_o,
  output tone_e            cls_tone_o
);
  localparam logic [SMP_W-1:0] THR_C   = SMP_W'(THRESH);
  localparam logic [CNT_W-1:0] SPLIT_C = CNT_W'(SPLIT);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             bit_now;
  logic             prev_q;
  logic             synced_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise;

  // Slicer: level at or above the threshold is a one.
  assign bit_now = (smp_i >= THR_C);
  // prev_q resets high so the first sample can never look like a rising edge.
  assign rise    = bit_now & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b1;
      synced_q <= 1'b0;
      cnt_q    <= '0;
    end else if (acc_i) begin
      prev_q <= bit_now;
      if (rise) begin
        synced_q <= 1'b1;
        cnt_q    <= CNT_W'(1);
      end else if (cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cls_fire_o = acc_i & rise & synced_q;
  assign cls_tone_o = (cnt_q < SPLIT_C) ? TONE_SHORT : TONE_LONG;

  // R8: a full counter stays full until the next edge.
  p_cnt_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i && !rise && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/fsk_run_quant.sv
module fsk_run_quant
  import fsk_pkg::*;
#(
  parameter int RUN_W    = 6,
  parameter int SHORT_DIV = 6,
  parameter int LONG_DIV  = 5,
  parameter int MAX_EMIT = 4,
  parameter int EMIT_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cls_fire_i,
  input  tone_e             cls_tone_i,
  output logic              emit_o,
  output logic [EMIT_W-1:0] emit_cnt_o,
  output logic              emit_sym_o
);
  localparam logic [RUN_W-1:0] LEN_MAX = {RUN_W{1'b1}};
  localparam logic [RUN_W:0]   SDIV_C  = (RUN_W+1)'(SHORT_DIV);
  localparam logic [RUN_W:0]   LDIV_C  = (RUN_W+1)'(LONG_DIV);
  localparam logic [RUN_W:0]   MAXE_C  = (RUN_W+1)'(MAX_EMIT);

  logic             active_q;
  tone_e            tone_q;
  logic [RUN_W-1:0] len_q;
  logic [RUN_W:0]   len_p1;
  logic [RUN_W:0]   hb;
  logic             closes;

  assign len_p1 = {1'b0, len_q} + 1'b1;
  assign hb     = (tone_q == TONE_LONG) ? (len_p1 / LDIV_C) : (len_p1 / SDIV_C);
  assign closes = cls_fire_i & active_q & (cls_tone_i != tone_q);

  assign emit_o     = closes && (hb != '0) && (hb <= MAXE_C);
  assign emit_cnt_o = EMIT_W'(hb);
  assign emit_sym_o = tone_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      tone_q   <= TONE_SHORT;
      len_q    <= '0;
    end else if (cls_fire_i) begin
      if (!active_q || closes) begin
        active_q <= 1'b1;
        tone_q   <= cls_tone_i;
        len_q    <= RUN_W'(1);
      end else if (len_q != LEN_MAX) begin
        len_q <= len_q + 1'b1;
      end
    end
  end

  // R4: a run that has started never returns to the empty state.
  p_run_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |=> active_q);
endmodule

// File: rtl/fsk_sym_emit.sv
module fsk_sym_emit #(
  parameter int EMIT_W   = 3,
  parameter int MAX_EMIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [EMIT_W-1:0] cnt_i,
  input  logic              sym_i,
  input  logic              out_ready_i,
  output logic              out_valid_o,
  output logic              out_bit_o,
  output logic              idle_o
);
  localparam logic [EMIT_W-1:0] MAXE_C = EMIT_W'(MAX_EMIT);

  logic [EMIT_W-1:0] left_q;
  logic              bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      bit_q  <= 1'b0;
    end else if (load_i) begin
      left_q <= cnt_i;
      bit_q  <= sym_i;
    end else if (left_q != '0 && out_ready_i) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign out_valid_o = (left_q != '0);
  assign out_bit_o   = bit_q;
  assign idle_o      = (left_q == '0);

  // R9: a new run is only loaded once every pending symbol has gone.
  p_load_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> (left_q == '0));
  // R6: the quantiser only ever asks for 1 to MAX_EMIT symbols.
  p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> (cnt_i != '0 && cnt_i <= MAXE_C));
  // R9: a stalled beat is held unchanged.
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_bit_o)));
endmodule

// File: rtl/fsk_halfbit_recover.sv
module fsk_halfbit_recover
  import fsk_pkg::*;
#(
  parameter int SMP_W     = 8,
  parameter int THRESH    = 127,
  parameter int CNT_W     = 4,
  parameter int SPLIT     = 9,
  parameter int RUN_W     = 6,
  parameter int SHORT_DIV = 6,
  parameter int LONG_DIV  = 5,
  parameter int MAX_EMIT  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  output logic             smp_ready,
  input  logic [SMP_W-1:0] smp_data,
  output logic             sym_valid,
  input  logic             sym_ready,
  output logic             sym_bit
);
  localparam int EMIT_W = $clog2(MAX_EMIT + 1);

  logic              acc;
  logic              cls_fire;
  tone_e             cls_tone;
  logic              emit;
  logic [EMIT_W-1:0] emit_cnt;
  logic              emit_sym;
  logic              idle;

  assign smp_ready = idle;
  assign acc       = smp_valid & idle;

  fsk_edge_timer #(
    .SMP_W(SMP_W), .THRESH(THRESH), .CNT_W(CNT_W), .SPLIT(SPLIT)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .acc_i(acc), .smp_i(smp_data),
    .cls_fire_o(cls_fire), .cls_tone_o(cls_tone)
  );

  fsk_run_quant #(
    .RUN_W(RUN_W), .SHORT_DIV(SHORT_DIV), .LONG_DIV(LONG_DIV),
    .MAX_EMIT(MAX_EMIT), .EMIT_W(EMIT_W)
  ) u_quant (
    .clk(clk), .rst_n(rst_n), .cls_fire_i(cls_fire), .cls_tone_i(cls_tone),
    .emit_o(emit), .emit_cnt_o(emit_cnt), .emit_sym_o(emit_sym)
  );

  fsk_sym_emit #(
    .EMIT_W(EMIT_W), .MAX_EMIT(MAX_EMIT)
  ) u_emit (
    .clk(clk), .rst_n(rst_n), .load_i(emit), .cnt_i(emit_cnt), .sym_i(emit_sym),
    .out_ready_i(sym_ready), .out_valid_o(sym_valid), .out_bit_o(sym_bit),
    .idle_o(idle)
  );
endmodule

// File: tb/fsk_halfbit_recover_bench.sv
module fsk_halfbit_recover_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_valid = 1'b0;
  logic       smp_ready;
  logic [7:0] smp_data = 8'd0;
  logic       sym_valid;
  logic       sym_ready = 1'b0;
  logic       sym_bit;

  int checks = 0;
  int fails  = 0;
  int got    = 0;
  bit exp_q[$];
  bit ready_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  // reference state (from the requirements)
  int m_prev, m_synced, m_cnt, m_active, m_tone, m_len;

  always #4 clk = ~clk;

  fsk_halfbit_recover u_fsk_halfbit_recover (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .sym_valid(sym_valid), .sym_ready(sym_ready),
    .sym_bit(sym_bit)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_prev = 1; m_synced = 0; m_cnt = 0; m_active = 0; m_tone = 0; m_len = 0;
  endtask

  task automatic model_run(input int c);
    if (!m_active) begin
      m_active = 1; m_tone = c; m_len = 1;
    end else if (c == m_tone) begin
      if (m_len < 63) m_len++;
    end else begin
      int hb;
      hb = (m_len + 1) / (m_tone ? 5 : 6);
      if (hb >= 1 && hb <= 4)
        for (int k = 0; k < hb; k++) exp_q.push_back(m_tone[0]);
      m_tone = c; m_len = 1;
    end
  endtask

  task automatic model_step(input int v);
    int b;
    b = (v >= 127) ? 1 : 0;
    if (b == 1 && m_prev == 0) begin
      if (m_synced) model_run((m_cnt < 9) ? 0 : 1);
      m_synced = 1; m_cnt = 1;
    end else if (m_cnt < 15) m_cnt++;
    m_prev = b;
  endtask

  // driver: one sample, blocking until the handshake completes
  task automatic send(input int v);
    model_step(v);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = 8'(v);
    forever begin
      #3;
      if (smp_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
  endtask

  task automatic cyc(input int p, input int hi, input int lo);
    send(hi);
    for (int k = 1; k < p; k++) send(lo);
  endtask

  task automatic tone(input int p, input int n);
    for (int k = 0; k < n; k++) cyc(p, 200, 40);
  endtask

  task automatic drain();
    @(negedge clk);
    smp_valid = 1'b0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && !sym_valid) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    smp_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    model_reset();
    exp_q.delete();
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // main directed pattern: expected 1 00 11 0 111 0000 1 (14 symbols)
  task automatic main_pattern(input int hi, input int lo);
    for (int k = 0; k < 5;  k++) cyc(10, hi, lo);
    for (int k = 0; k < 12; k++) cyc(8,  hi, lo);
    for (int k = 0; k < 10; k++) cyc(10, hi, lo);
    for (int k = 0; k < 6;  k++) cyc(8,  hi, lo);
    for (int k = 0; k < 15; k++) cyc(10, hi, lo);
    for (int k = 0; k < 24; k++) cyc(8,  hi, lo);
    for (int k = 0; k < 30; k++) cyc(10, hi, lo);
    for (int k = 0; k < 3;  k++) cyc(8,  hi, lo);
    for (int k = 0; k < 5;  k++) cyc(10, hi, lo);
    for (int k = 0; k < 6;  k++) cyc(8,  hi, lo);
    send(hi);
  endtask

  // ready pattern, changed away from the clock edge
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    sym_ready = ready_mode ? lfsr[0] : 1'b1;
  end

  // monitor / scoreboard, sampling 1 ns before the rising edge
  always @(negedge clk) begin
    #3;
    if (rst_n && sym_valid) begin
      // R9: input must be stalled while a symbol is pending
      check(!smp_ready, "R9 smp_ready while pending", int'(smp_ready), 0);
      if (sym_ready) begin
        got++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 R6 unexpected symbol", int'(sym_bit), -1);
        end else begin
          bit e;
          e = exp_q.pop_front();
          check(sym_bit == e, "R4 R5 R7 symbol value", int'(sym_bit), int'(e));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R9 watchdog progress", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int base;
    model_reset();
    repeat (3) @(negedge clk);
    // R10: reset state
    check(sym_valid == 1'b0, "R10 sym_valid in reset", int'(sym_valid), 0);
    check(smp_ready == 1'b1, "R10 smp_ready in reset", int'(smp_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(sym_valid == 1'b0, "R10 sym_valid after reset", int'(sym_valid), 0);

    // R2: no rising edge yet -> nothing measured, nothing emitted
    base = got;
    for (int k = 0; k < 40; k++) send(200);
    for (int k = 0; k < 40; k++) send(40);
    send(200);
    for (int k = 0; k < 60; k++) send(40);
    drain();
    check(got == base, "R2 no output before measured spacings", got - base, 0);
    do_reset();

    // R5 R6 R7: main pattern with clean levels
    base = got;
    main_pattern(200, 40);
    drain();
    check(got - base == 14, "R5 R6 symbol count", got - base, 14);
    check(exp_q.size() == 0, "R6 all expected delivered", exp_q.size(), 0);
    do_reset();

    // R3: noisy spacings 7..11
    base = got;
    cyc(9, 200, 40); cyc(11, 200, 40); cyc(10, 200, 40); cyc(9, 200, 40); cyc(11, 200, 40);
    for (int k = 0; k < 6; k++) begin cyc(7, 200, 40); cyc(8, 200, 40); end
    for (int k = 0; k < 5; k++) cyc(11, 200, 40);
    cyc(7, 200, 40);
    send(200);
    drain();
    check(got - base == 4, "R3 noisy classification count", got - base, 4);
    do_reset();

    // R8: long gap must classify as long tone (expected 0 1 0)
    base = got;
    tone(8, 6);
    tone(10, 3);
    cyc(24, 200, 40);
    tone(8, 6);
    tone(10, 5);
    send(200);
    drain();
    check(got - base == 3, "R8 saturating gap count", got - base, 3);
    do_reset();

    // R1: levels right at the threshold (127 high, 126 low)
    base = got;
    main_pattern(127, 126);
    drain();
    check(got - base == 14, "R1 threshold edge count", got - base, 14);
    do_reset();

    // R9: back-pressure on the output
    ready_mode = 1'b1;
    base = got;
    main_pattern(200, 40);
    drain();
    check(got - base == 14, "R9 count under back-pressure", got - base, 14);
    check(exp_q.size() == 0, "R9 nothing lost", exp_q.size(), 0);
    ready_mode = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule